// File: doc/BRIEF.md
# Refresh DMA Bus Arbiter

This block decides when a periodic memory-refresh request may take the system bus away from the processor's bus-cycle sequencer. It runs two state machines side by side. One follows the processor bus phases: idle, T1, T2, T3, T4 and an inserted wait phase. The other follows the refresh transfer: request pending, hold, address enable, S0, S1, S2, S3 and S4. The refresh claims the bus only when the processor bus is passive. Any processor cycle that is requested while the refresh owns the bus is held in wait phases until address enable drops, and then starts at T1.

The number of wait cycles a processor access absorbs depends on where the refresh request lands relative to the processor's bus phases. It is zero when the processor bus is idle, and at most six when a new access is requested just as the refresh seizes the bus. A saturating counter of inserted wait cycles is exposed for checking. A refresh request is only honoured while the channel is armed for a transfer. A request that arrives during a refresh in progress is remembered and served right after it.

Top module: `refresh_arbiter`

## Requirements
- R1: After reset, addrEnable, dmaAck and refreshStrobe are 0, cpuReady is 1, cpuPhase is 0 (idle) and waitCount is 0.
- R2: dmaAck rises no earlier than the fourth rising edge after the edge that samples an armed refreshReq, and exactly on the fourth edge when the processor bus is idle.
- R3: addrEnable is never high while the processor is in T1, T2 or T3 (cpuPhase 1, 2, 3). A refresh requested during a processor cycle gets addrEnable only after that cycle reaches T4.
- R4: dmaAck is high in S1, S2 and S3. It drops in S4 while addrEnable stays high for that one cycle, and addrEnable drops on the next cycle.
- R5: refreshStrobe is high for exactly one cycle, in S3, while dmaAck is high. dmaPhase encodes idle=0, request=1, hold=2, address enable=3, S0=4, S1=5, S2=6, S3=7, S4=8.
- R6: A processor bus cycle requested while the refresh owns the bus is held with cpuReady low and cpuPhase 5 (wait). It enters T1 (cpuPhase 1) in the cycle in which addrEnable has dropped.
- R7: waitCount increases by one for each held cycle. A refresh adds 0 when the processor bus is idle, and never more than 6 per refresh.
- R8: A refreshReq while channelArmed is low has no effect: no address enable, no acknowledge, and dmaPhase stays 0.
- R9: A refreshReq accepted while a refresh is in progress is served next. dmaPhase is 1 in the cycle after S4, and the second transfer runs the full S0 to S4 sequence.
- R10: waitCount saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refreshReq | input | 1 | Periodic refresh request pulse |
| channelArmed | input | 1 | Refresh channel programmed for a transfer |
| cpuReq | input | 1 | Processor wants a bus cycle |
| dmaAck | output | 1 | Refresh acknowledge (S1 to S3) |
| addrEnable | output | 1 | Refresh owns the address bus |
| cpuReady | output | 1 | Low while a processor cycle is held |
| refreshStrobe | output | 1 | Refresh read strobe in S3 |
| cpuPhase | output | 3 | Processor bus phase code |
| dmaPhase | output | 4 | Refresh phase code |
| waitCount | output | CntW | Saturating count of inserted wait cycles |

## Verification
The embedded properties hold on every cycle. They check that addrEnable never overlaps T1 to T3, that the acknowledge and the strobe sit inside the address-enable window, that addrEnable falls right after the acknowledge, that a held processor cycle only ever sits under address enable, that no hold run exceeds six cycles, and that the counter grows with each hold and saturates. Only the bench scenarios can show the exact latencies. These are the four-edge acknowledge with an idle processor, the delay when a processor cycle is in flight, the five-wait and six-wait placements, the ignored request on an unarmed channel, and the chaining of a request that lands mid-refresh.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;

  typedef enum logic [2:0] {
    CPU_IDLE = 3'd0,
    CPU_T1   = 3'd1,
    CPU_T2   = 3'd2,
    CPU_T3   = 3'd3,
    CPU_T4   = 3'd4,
    CPU_TW   = 3'd5
  } cpuState_t;

  typedef enum logic [3:0] {
    DMA_IDLE = 4'd0,
    DMA_REQ  = 4'd1,
    DMA_HOLD = 4'd2,
    DMA_AEN  = 4'd3,
    DMA_S0   = 4'd4,
    DMA_S1   = 4'd5,
    DMA_S2   = 4'd6,
    DMA_S3   = 4'd7,
    DMA_S4   = 4'd8
  } dmaState_t;

  typedef struct packed {
    logic incWait;
    logic setPend;
    logic clrPend;
  } arbStrobe_t;

  localparam int MaxHeld = 6;

endpackage

// File: rtl/arb_ctrl.sv
`timescale 1ns/1ps
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refreshReq,
  input  logic       channelArmed,
  input  logic       cpuReq,
  input  logic       pending,
  output arbStrobe_t strobes,
  output logic       dmaAck,
  output logic       addrEnable,
  output logic       cpuReady,
  output logic       refreshStrobe,
  output logic [2:0] cpuPhase,
  output logic [3:0] dmaPhase
);

  cpuState_t cpuState, cpuNext;
  dmaState_t dmaState, dmaNext;
  logic reqAccept;
  logic cpuPassive;
  logic busClaim;

  assign reqAccept  = refreshReq && channelArmed;
  assign cpuPassive = (cpuState == CPU_IDLE) || (cpuState == CPU_T4) ||
                      (cpuState == CPU_TW);
  // The refresh is committing to, or already holding, the bus.
  assign busClaim   = ((dmaState == DMA_HOLD) && cpuPassive) ||
                      (dmaState == DMA_AEN) || (dmaState == DMA_S0) ||
                      (dmaState == DMA_S1) || (dmaState == DMA_S2) ||
                      (dmaState == DMA_S3);

  always_comb begin
    dmaNext = dmaState;
    unique case (dmaState)
      DMA_IDLE: if (reqAccept) dmaNext = DMA_REQ;
      DMA_REQ:  dmaNext = DMA_HOLD;
      DMA_HOLD: if (cpuPassive) dmaNext = DMA_AEN;
      DMA_AEN:  dmaNext = DMA_S0;
      DMA_S0:   dmaNext = DMA_S1;
      DMA_S1:   dmaNext = DMA_S2;
      DMA_S2:   dmaNext = DMA_S3;
      DMA_S3:   dmaNext = DMA_S4;
      DMA_S4:   dmaNext = (pending || reqAccept) ? DMA_REQ : DMA_IDLE;
      default:  dmaNext = DMA_IDLE;
    endcase
  end

  always_comb begin
    cpuNext = cpuState;
    unique case (cpuState)
      CPU_IDLE, CPU_T4:
        if (cpuReq) cpuNext = busClaim ? CPU_TW : CPU_T1;
        else        cpuNext = CPU_IDLE;
      CPU_T1:  cpuNext = CPU_T2;
      CPU_T2:  cpuNext = CPU_T3;
      CPU_T3:  cpuNext = CPU_T4;
      CPU_TW:  cpuNext = busClaim ? CPU_TW : CPU_T1;
      default: cpuNext = CPU_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaState <= DMA_IDLE;
      cpuState <= CPU_IDLE;
    end else begin
      dmaState <= dmaNext;
      cpuState <= cpuNext;
    end
  end

  assign strobes.incWait = (cpuState == CPU_TW);
  assign strobes.setPend = reqAccept && (dmaState != DMA_IDLE) &&
                           (dmaState != DMA_S4);
  assign strobes.clrPend = (dmaState == DMA_S4);

  assign dmaAck        = (dmaState == DMA_S1) || (dmaState == DMA_S2) ||
                         (dmaState == DMA_S3);
  assign addrEnable    = (dmaState == DMA_AEN) || (dmaState == DMA_S0) ||
                         dmaAck || (dmaState == DMA_S4);
  assign refreshStrobe = (dmaState == DMA_S3);
  assign cpuReady      = (cpuState != CPU_TW);
  assign cpuPhase      = cpuState;
  assign dmaPhase      = dmaState;

  // Length of the current run of held cycles, for the bound check.
  logic [3:0] heldRun;
  always_ff @(posedge clk) begin
    if (!rstN)                  heldRun <= '0;
    else if (cpuState == CPU_TW) heldRun <= heldRun + 4'd1;
    else                         heldRun <= '0;
  end

  AST_AEN_OUTSIDE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    addrEnable |-> !(cpuPhase inside {3'd1, 3'd2, 3'd3})); // R3
  AST_ACK_UNDER_AEN: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |-> addrEnable); // R4
  AST_AEN_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaAck) |=> !addrEnable); // R4
  AST_STROBE_UNDER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    refreshStrobe |-> dmaAck); // R5
  AST_HELD_UNDER_AEN: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReady |-> addrEnable); // R6
  AST_HELD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    heldRun <= 4'(MaxHeld)); // R7

endmodule

// File: rtl/arb_datapath.sv
`timescale 1ns/1ps
module arb_datapath
  import arb_pkg::*;
#(
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  arbStrobe_t      strobes,
  output logic            pending,
  output logic [CntW-1:0] waitCount
);

  localparam logic [CntW-1:0] CntMax = {CntW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN)                 pending <= 1'b0;
    else if (strobes.clrPend)  pending <= 1'b0;
    else if (strobes.setPend)  pending <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      waitCount <= '0;
    else if (strobes.incWait && (waitCount != CntMax))
      waitCount <= waitCount + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (waitCount == CntMax) |=> (waitCount == CntMax)); // R10

endmodule

// File: rtl/refresh_arbiter.sv
`timescale 1ns/1ps
module refresh_arbiter
  import arb_pkg::*;
#(
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refreshReq,
  input  logic            channelArmed,
  input  logic            cpuReq,
  output logic            dmaAck,
  output logic            addrEnable,
  output logic            cpuReady,
  output logic            refreshStrobe,
  output logic [2:0]      cpuPhase,
  output logic [3:0]      dmaPhase,
  output logic [CntW-1:0] waitCount
);

  arbStrobe_t strobes;
  logic       pending;

  arb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .refreshReq(refreshReq),
    .channelArmed(channelArmed), .cpuReq(cpuReq), .pending(pending),
    .strobes(strobes), .dmaAck(dmaAck), .addrEnable(addrEnable),
    .cpuReady(cpuReady), .refreshStrobe(refreshStrobe),
    .cpuPhase(cpuPhase), .dmaPhase(dmaPhase)
  );

  arb_datapath #(.CntW(CntW)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pending(pending), .waitCount(waitCount)
  );

  AST_WAIT_TRACKS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuReady && (waitCount != {CntW{1'b1}})) |=>
      (waitCount != $past(waitCount))); // R7

endmodule

// File: tb/test_refresh_arbiter.sv
`timescale 1ns/1ps
module test_refresh_arbiter;

  localparam int CntW = 8;
  localparam int CntMax = (1 << CntW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refreshReq = 1'b0;
  logic channelArmed = 1'b1;
  logic cpuReq = 1'b0;
  logic dmaAck, addrEnable, cpuReady, refreshStrobe;
  logic [2:0] cpuPhase;
  logic [3:0] dmaPhase;
  logic [CntW-1:0] waitCount;

  refresh_arbiter #(.CntW(CntW)) i_refresh_arbiter (
    .clk(clk), .rstN(rstN), .refreshReq(refreshReq),
    .channelArmed(channelArmed), .cpuReq(cpuReq), .dmaAck(dmaAck),
    .addrEnable(addrEnable), .cpuReady(cpuReady),
    .refreshStrobe(refreshStrobe), .cpuPhase(cpuPhase),
    .dmaPhase(dmaPhase), .waitCount(waitCount)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    cyc;
    int    sig;
    int    val;
    string req;
  } expect_t;

  localparam int SIG_AEN = 0, SIG_ACK = 1, SIG_STB = 2, SIG_RDY = 3,
                 SIG_CPU = 4, SIG_CNT = 5, SIG_DMA = 6;

  expect_t sb[$];
  expect_t item;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int expWait = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  function automatic int sampleSig(int s);
    case (s)
      SIG_AEN: return int'(addrEnable);
      SIG_ACK: return int'(dmaAck);
      SIG_STB: return int'(refreshStrobe);
      SIG_RDY: return int'(cpuReady);
      SIG_CPU: return int'(cpuPhase);
      SIG_CNT: return int'(waitCount);
      default: return int'(dmaPhase);
    endcase
  endfunction

  function automatic string sigName(int s);
    case (s)
      SIG_AEN: return "addrEnable";
      SIG_ACK: return "dmaAck";
      SIG_STB: return "refreshStrobe";
      SIG_RDY: return "cpuReady";
      SIG_CPU: return "cpuPhase";
      SIG_CNT: return "waitCount";
      default: return "dmaPhase";
    endcase
  endfunction

  task automatic expectAt(int c, int s, int v, string req);
    expect_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic bumpWait(int n);
    expWait = (expWait + n > CntMax) ? CntMax : expWait + n;
  endtask

  // Monitor: compares each queued expectation in its cycle.
  always @(negedge clk) begin
    if (rstN && !done) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        item = sb.pop_front();
        checks++;
        if (sampleSig(item.sig) != item.val) begin
          fails++;
          $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", item.req,
                   sigName(item.sig), sampleSig(item.sig), item.val, cyc);
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Refresh with the processor bus idle throughout.
  task automatic idleRefresh();
    int r;
    r = cyc;
    refreshReq = 1'b1;
    expectAt(r + 2, SIG_AEN, 0, "R3");
    expectAt(r + 3, SIG_AEN, 1, "R3");
    expectAt(r + 4, SIG_ACK, 0, "R2");
    expectAt(r + 5, SIG_ACK, 1, "R2");
    expectAt(r + 5, SIG_RDY, 1, "R7");
    expectAt(r + 6, SIG_STB, 0, "R5");
    expectAt(r + 7, SIG_STB, 1, "R5");
    expectAt(r + 7, SIG_DMA, 7, "R5");
    expectAt(r + 8, SIG_ACK, 0, "R4");
    expectAt(r + 8, SIG_AEN, 1, "R4");
    expectAt(r + 8, SIG_STB, 0, "R5");
    expectAt(r + 9, SIG_AEN, 0, "R4");
    expectAt(r + 9, SIG_CNT, expWait, "R7");
    @(negedge clk); refreshReq = 1'b0;
    idle(10);
  endtask

  // Processor asks for the bus while address enable is already up: 5 waits.
  task automatic heldDuringAen();
    int r;
    r = cyc;
    refreshReq = 1'b1;
    expectAt(r + 3, SIG_CPU, 0, "R6");
    expectAt(r + 4, SIG_CPU, 5, "R6");
    expectAt(r + 4, SIG_RDY, 0, "R6");
    expectAt(r + 8, SIG_RDY, 0, "R6");
    expectAt(r + 8, SIG_AEN, 1, "R6");
    expectAt(r + 9, SIG_CPU, 1, "R6");
    expectAt(r + 9, SIG_RDY, 1, "R6");
    expectAt(r + 9, SIG_AEN, 0, "R6");
    bumpWait(5);
    expectAt(r + 13, SIG_CNT, expWait, "R7");
    @(negedge clk); refreshReq = 1'b0;
    idle(2); cpuReq = 1'b1;
    idle(6); cpuReq = 1'b0;
    idle(8);
  endtask

  // Processor cycle in flight when the request lands: worst case, 6 waits.
  task automatic worstCase(bit full);
    int r;
    r = cyc;
    refreshReq = 1'b1;
    if (full) begin
      expectAt(r + 2, SIG_CPU, 1, "R3");
      expectAt(r + 4, SIG_AEN, 0, "R3");
      expectAt(r + 5, SIG_AEN, 0, "R3");
      expectAt(r + 5, SIG_CPU, 4, "R3");
      expectAt(r + 6, SIG_AEN, 1, "R3");
      expectAt(r + 6, SIG_CPU, 5, "R6");
      expectAt(r + 7, SIG_ACK, 0, "R2");
      expectAt(r + 8, SIG_ACK, 1, "R2");
      expectAt(r + 11, SIG_CPU, 5, "R6");
      expectAt(r + 12, SIG_CPU, 1, "R6");
      expectAt(r + 12, SIG_AEN, 0, "R6");
    end
    bumpWait(6);
    expectAt(r + 16, SIG_CNT, expWait, full ? "R7" : "R10");
    @(negedge clk); refreshReq = 1'b0; cpuReq = 1'b1;
    idle(11); cpuReq = 1'b0;
    idle(6);
  endtask

  // Channel not armed: request is ignored.
  task automatic unarmedRequest();
    int r;
    r = cyc;
    channelArmed = 1'b0;
    refreshReq = 1'b1;
    expectAt(r + 1, SIG_DMA, 0, "R8");
    expectAt(r + 3, SIG_AEN, 0, "R8");
    expectAt(r + 5, SIG_ACK, 0, "R8");
    expectAt(r + 7, SIG_STB, 0, "R8");
    expectAt(r + 7, SIG_DMA, 0, "R8");
    @(negedge clk); refreshReq = 1'b0;
    idle(8);
    channelArmed = 1'b1;
    idle(2);
  endtask

  // Second request lands during S0 and is chained after S4.
  task automatic chainedRequest();
    int r;
    r = cyc;
    refreshReq = 1'b1;
    expectAt(r + 8, SIG_AEN, 1, "R9");
    expectAt(r + 8, SIG_ACK, 0, "R9");
    expectAt(r + 9, SIG_AEN, 0, "R9");
    expectAt(r + 9, SIG_DMA, 1, "R9");
    expectAt(r + 11, SIG_AEN, 1, "R9");
    expectAt(r + 13, SIG_ACK, 1, "R9");
    expectAt(r + 15, SIG_STB, 1, "R9");
    expectAt(r + 16, SIG_DMA, 8, "R9");
    expectAt(r + 17, SIG_AEN, 0, "R9");
    expectAt(r + 17, SIG_DMA, 0, "R9");
    @(negedge clk); refreshReq = 1'b0;
    idle(3); refreshReq = 1'b1;
    @(negedge clk); refreshReq = 1'b0;
    idle(18);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    expectAt(1, SIG_AEN, 0, "R1");
    expectAt(1, SIG_ACK, 0, "R1");
    expectAt(1, SIG_STB, 0, "R1");
    expectAt(1, SIG_RDY, 1, "R1");
    expectAt(1, SIG_CPU, 0, "R1");
    expectAt(1, SIG_CNT, 0, "R1");
    idle(3);
    idleRefresh();
    heldDuringAen();
    worstCase(1'b1);
    unarmedRequest();
    chainedRequest();
    for (int k = 0; k < 45; k++) worstCase(1'b0);
    expectAt(cyc + 1, SIG_CNT, CntMax, "R10");
    idleRefresh();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    finishRun();
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, %0d expectations pending", sb.size());
      finishRun();
    end
  end

endmodule